// File: doc/BRIEF.md
# Byte-Addressed GPIO Port Core with Change Interrupt

This block is the register core of a general-purpose I/O port controlled by a byte-serial host. A host front end, which is not part of this block, decodes the bus and presents three things to the core: a marker that a write transfer has begun, a strobe for each written byte, and a strobe for each read byte. The first byte written after the marker sets a register pointer. Any further bytes in that transfer go to the register that the pointer selects. Reads always return the register under the current pointer.

There are four registers. The input view is read only. The other three are the output latch, a per-bit read polarity mask and a per-bit direction control. The core drives a value and an output enable for each pin. It passes the incoming pin levels through a synchronizer. It raises an active-low interrupt when an input-configured pin differs from a snapshot of the pin levels. That snapshot is taken at reset and again whenever the input view is read.

Top module: `gpio_expander_core`

## Requirements
- R1: While reset is high, and after it is released, the output latch is 0xFF, the polarity mask is 0x00, the direction register is 0xFF, pin_oe is all zeros, the pointer is 0 and the next written byte is taken as a pointer. int_n stays high when the pins are stable across reset.
- R2: After a host_start pulse, the first host_wr byte loads the pointer. Every later byte up to the next host_start is written to the selected register, and the pointer does not advance. The pointer keeps its value across transfers.
- R3: Pointer 0 reads back the synchronized pin level XOR the polarity mask for every pin, whatever its direction. Writes with pointer 0 change no register.
- R4: Pointer 1 reads back the stored output latch, not the level seen on pin_in.
- R5: Pointer 3 is the direction register: bit value 1 means input (pin_oe bit 0) and bit value 0 means output (pin_oe bit 1). pin_out always carries the output latch.
- R6: Pointer 2 holds the polarity mask. A 1 inverts that bit of the pointer-0 read data, and a 0 passes the bit through.
- R7: Pointer values 4 to 255 select nothing. Writes to them change no register and reads return 0x00.
- R8: int_n is low exactly when some pin with direction bit 1 has a synchronized raw level, taken before polarity, that differs from the snapshot. Pins configured as outputs never affect int_n.
- R9: int_n returns high with no host access once the changed input goes back to its snapshot level.
- R10: A host_rd with pointer 0 reloads the snapshot from the synchronized pins, so int_n is high in the following cycle when the pins are stable.
- R11: Switching a pin from output to input while its level differs from the snapshot drives int_n low.
- R12: A pin_in change reaches the read data and int_n after exactly two clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_start | input | 1 | Marks the start of a write transfer |
| host_wr | input | 1 | Write byte strobe |
| host_wdata | input | W | Written byte |
| host_rd | input | 1 | Read byte strobe (data taken this cycle) |
| host_rdata | output | W | Contents of the selected register |
| pin_in | input | W | Incoming pin levels (asynchronous) |
| pin_out | output | W | Output latch value for each pin |
| pin_oe | output | W | Output enable for each pin, 1 = driven |
| int_n | output | 1 | Change interrupt, active low |

## Verification
The bench forces pin levels that disagree with the output latch, so a design that read back the pin instead of the latch shows up as an R4 failure. It holds the polarity mask non-zero while the input view is read, and also while pins toggle, which catches a design that compared inverted levels for the interrupt. It counts edges to pin down the two-stage latency, so a design with one stage or three misses R12. It flips a pin while that pin is configured as an output and then turns it into an input, which catches both a design that masked the resulting spurious interrupt and one that let output pins raise it. Writes through pointer 0, through pointers above 3, and a second data byte in one transfer expose pointer decoding and any auto-increment.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    // Register pointer codes; the host selects registers by these values.
    localparam int unsigned SEL_IN  = 0;
    localparam int unsigned SEL_OUT = 1;
    localparam int unsigned SEL_POL = 2;
    localparam int unsigned SEL_DIR = 3;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) stage_q[0] <= async_in;

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_start,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         host_rd,
    input  logic [W-1:0] in_sync,
    output logic [W-1:0] rd_data,
    output logic         snap_load,
    output logic [W-1:0] ptr_q,
    output logic         want_ptr_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] dir_q
);
    localparam logic [W-1:0] P_IN  = W'(SEL_IN);
    localparam logic [W-1:0] P_OUT = W'(SEL_OUT);
    localparam logic [W-1:0] P_POL = W'(SEL_POL);
    localparam logic [W-1:0] P_DIR = W'(SEL_DIR);

    typedef struct packed {
        logic [W-1:0] ptr;
        logic         want_ptr;
        logic [W-1:0] out;
        logic [W-1:0] pol;
        logic [W-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (host_start) begin
            r_d.want_ptr = 1'b1;
        end else if (host_wr) begin
            if (r_q.want_ptr) begin
                r_d.ptr      = host_wdata;
                r_d.want_ptr = 1'b0;
            end else if (r_q.ptr == P_OUT) begin
                r_d.out = host_wdata;
            end else if (r_q.ptr == P_POL) begin
                r_d.pol = host_wdata;
            end else if (r_q.ptr == P_DIR) begin
                r_d.dir = host_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.ptr      <= '0;
            r_q.want_ptr <= 1'b1;
            r_q.out      <= '1;
            r_q.pol      <= '0;
            r_q.dir      <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (r_q.ptr == P_IN)       rd_data = in_sync ^ r_q.pol;
        else if (r_q.ptr == P_OUT) rd_data = r_q.out;
        else if (r_q.ptr == P_POL) rd_data = r_q.pol;
        else if (r_q.ptr == P_DIR) rd_data = r_q.dir;
        else                       rd_data = '0;
    end

    assign snap_load  = host_rd && (r_q.ptr == P_IN);
    assign ptr_q      = r_q.ptr;
    assign want_ptr_q = r_q.want_ptr;
    assign out_q      = r_q.out;
    assign pol_q      = r_q.pol;
    assign dir_q      = r_q.dir;
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_sync,
    input  logic [W-1:0] dir,
    input  logic         snap_load,
    output logic [W-1:0] snap_q,
    output logic         int_n
);
    typedef struct packed {
        logic [W-1:0] snap;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (snap_load) s_d.snap = in_sync;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.snap <= in_sync;
        else     s_q      <= s_d;
    end

    assign snap_q = s_q.snap;
    assign int_n  = ~|((in_sync ^ s_q.snap) & dir);
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_start,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         host_rd,
    output logic [W-1:0] host_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic         int_n
);
    logic [W-1:0] in_sync;
    logic         snap_load;
    logic [W-1:0] ptr_q, out_q, pol_q, dir_q, snap_q;
    logic         want_ptr_q;

    gpx_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    gpx_regfile #(.W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_start (host_start),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .in_sync    (in_sync),
        .rd_data    (host_rdata),
        .snap_load  (snap_load),
        .ptr_q      (ptr_q),
        .want_ptr_q (want_ptr_q),
        .out_q      (out_q),
        .pol_q      (pol_q),
        .dir_q      (dir_q)
    );

    gpx_irq #(.W(W)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .in_sync   (in_sync),
        .dir       (dir_q),
        .snap_load (snap_load),
        .snap_q    (snap_q),
        .int_n     (int_n)
    );

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         host_wr,
    input logic [W-1:0] host_wdata,
    input logic [W-1:0] host_rdata,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic         int_n,
    input logic [W-1:0] in_sync,
    input logic         snap_load,
    input logic [W-1:0] ptr_q,
    input logic         want_ptr_q,
    input logic [W-1:0] out_q,
    input logic [W-1:0] pol_q,
    input logic [W-1:0] dir_q
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '1 && ptr_q == '0 && want_ptr_q));

    p_ptr0_readonly_r3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !want_ptr_q && ptr_q == '0) |=> ({out_q, pol_q, dir_q} == $past({out_q, pol_q, dir_q})));

    p_dir_to_oe_r5: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !want_ptr_q && ptr_q == W'(3)) |=> (pin_oe == ~$past(host_wdata)));

    p_bad_ptr_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (ptr_q > W'(3)) |-> (host_rdata == '0));

    p_int_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && in_sync == $past(in_sync) && dir_q == $past(dir_q) && !$past(snap_load))
        |-> (int_n == $past(int_n)));

    p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
        snap_load |=> (int_n || in_sync != $past(in_sync)));
endmodule

bind gpio_expander_core gpx_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .int_n      (int_n),
    .in_sync    (in_sync),
    .snap_load  (snap_load),
    .ptr_q      (ptr_q),
    .want_ptr_q (want_ptr_q),
    .out_q      (out_q),
    .pol_q      (pol_q),
    .dir_q      (dir_q)
);

// File: tb/gpio_expander_core_test.sv
`timescale 1ns/1ps
module gpio_expander_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_start = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, pin_in = 8'hA5;
    logic [7:0] host_rdata, pin_out, pin_oe;
    logic       int_n;

    gpio_expander_core #(.W(8), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .host_start(host_start), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .int_n(int_n)
    );

    always #5 clk = ~clk;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [7:0] out_m = 8'hFF, pol_m = 8'h00, dir_m = 8'hFF, ptr_m = 8'h00;
    logic [7:0] snap_m = 8'hA5, pins = 8'hA5;

    function automatic logic [7:0] exp_rd();
        case (ptr_m)
            8'd0:    return pins ^ pol_m;
            8'd1:    return out_m;
            8'd2:    return pol_m;
            8'd3:    return dir_m;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_int_n();
        return ~|((pins ^ snap_m) & dir_m);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " rdata"}, host_rdata, exp_rd());
        chk({req, " int_n"}, {7'd0, int_n}, {7'd0, exp_int_n()});
        chk({req, " oe"}, pin_oe, ~dir_m);
        chk({req, " out"}, pin_out, out_m);
    endtask

    // Transfer: pointer byte, then each data byte goes to the selected register.
    task automatic xfer(logic [7:0] p, logic [7:0] d0, int nbytes, logic [7:0] d1);
        @(negedge clk) host_start = 1'b1;
        @(negedge clk) host_start = 1'b0; host_wr = 1'b1; host_wdata = p;
        ptr_m = p;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk) host_wdata = (i == 0) ? d0 : d1;
            case (p)
                8'd1: out_m = host_wdata;
                8'd2: pol_m = host_wdata;
                8'd3: dir_m = host_wdata;
                default: ;
            endcase
        end
        @(negedge clk) host_wr = 1'b0;
    endtask

    task automatic rd(string req);
        @(negedge clk) host_rd = 1'b1;
        chk(req, host_rdata, exp_rd());
        @(negedge clk) host_rd = 1'b0;
        if (ptr_m == 8'd0) snap_m = pins;
    endtask

    task automatic set_pins(logic [7:0] v);
        @(negedge clk) pin_in = v;
        pins = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset defaults
        chk_all("R1");
        xfer(8'd1, 8'h00, 0, 8'h00); rd("R1 out default");
        xfer(8'd2, 8'h00, 0, 8'h00); rd("R1 pol default");
        xfer(8'd3, 8'h00, 0, 8'h00); rd("R1 dir default");
        // R2 two data bytes, no increment, pointer kept
        xfer(8'd1, 8'h3C, 2, 8'h5A);
        rd("R2 second byte same reg");
        rd("R2 pointer kept");
        // R5 direction mapping
        xfer(8'd3, 8'h0F, 1, 8'h00);
        chk_all("R5");
        // R4 latch readback against forced pins
        set_pins(8'h00);
        xfer(8'd1, 8'h00, 0, 8'h00);
        rd("R4 latch not pin");
        chk("R4 pin_out", pin_out, 8'h5A);
        // R3 writes to pointer 0 ignored
        xfer(8'd0, 8'hFF, 2, 8'h77);
        rd("R3 input view");
        chk_all("R3");
        xfer(8'd1, 8'h00, 0, 8'h00); rd("R3 out unchanged");
        xfer(8'd3, 8'h00, 0, 8'h00); rd("R3 dir unchanged");
        // R6 polarity
        xfer(8'd2, 8'h0F, 1, 8'h00);
        set_pins(8'hC3);
        xfer(8'd0, 8'h00, 0, 8'h00);
        rd("R6 inverted read");
        chk_all("R6");
        // R7 unmapped pointers
        xfer(8'd7, 8'h12, 1, 8'h00); rd("R7 ptr7 reads zero");
        xfer(8'd255, 8'h34, 1, 8'h00); rd("R7 ptr255 reads zero");
        chk_all("R7");
        // R12 latency, with pointer 0 and all inputs
        xfer(8'd3, 8'hFF, 1, 8'h00);
        xfer(8'd2, 8'h00, 1, 8'h00);
        xfer(8'd0, 8'h00, 0, 8'h00);
        rd("R12 settle");
        @(negedge clk) pin_in = 8'h3C;
        @(negedge clk);
        chk("R12 one edge old", host_rdata, 8'hC3);
        chk("R12 one edge int", {7'd0, int_n}, 8'd1);
        @(negedge clk);
        pins = 8'h3C;
        chk("R12 two edges new", host_rdata, 8'h3C);
        chk("R12 two edges int", {7'd0, int_n}, 8'd0);
        // R10 read clears
        rd("R10 read");
        chk("R10 int cleared", {7'd0, int_n}, 8'd1);
        // R8 / R9 change then return
        set_pins(8'h3D);
        chk("R8 change asserts", {7'd0, int_n}, 8'd0);
        set_pins(8'h3C);
        chk("R9 return clears", {7'd0, int_n}, 8'd1);
        // R8 output pins ignored, R11 spurious on switch to input
        xfer(8'd3, 8'hF7, 1, 8'h00);
        set_pins(8'h34);
        chk("R8 output pin ignored", {7'd0, int_n}, 8'd1);
        xfer(8'd3, 8'hFF, 1, 8'h00);
        chk("R11 spurious after switch", {7'd0, int_n}, 8'd0);
        chk_all("R11");
        xfer(8'd0, 8'h00, 0, 8'h00);
        rd("R10 read after switch");
        chk_all("R10");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 3);
            logic [7:0] p = ($urandom_range(0, 7) == 7) ? 8'd200 : 8'($urandom_range(0, 4));
            if (op == 0)      xfer(p, 8'($urandom), $urandom_range(0, 2), 8'($urandom));
            else if (op == 1) rd("R2 random read");
            else              set_pins(8'($urandom));
            chk_all("R8 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule